// File: doc/BRIEF.md
# Half-Duplex SPI Slave Command Engine

This block is a four-wire SPI slave that runs a byte-oriented, opcode-driven half-duplex protocol. While chip select is low, the master shifts in an 8-bit opcode and then an 8-bit start address. After that come whole data bytes. The opcode picks one of five actions on two pieces of local storage. One is a 64-byte data buffer. The other is an 8-bit status register. Reads come back on MISO in the same frame, after the address.

All SPI pins are brought into the system clock domain through a short synchronizer. Edges are found there, so SCLK must run well below the system clock; the bench uses a ratio of 16. The system side has its own byte-wide port into the buffer. It can also see the status byte written by the master, and it supplies a second status byte. A select input chooses which of the two status bytes the master reads. A one-cycle done strobe reports every frame that completed, together with its opcode.

Top module: `spi_hd_slave`

## Requirements
- R1: A frame carries an 8-bit opcode, then an 8-bit address, then whole data bytes, all MSB first in SPI mode 0. MOSI is sampled on rising SCLK. MISO changes after falling SCLK, and the first data bit is valid before the first data rising edge.
- R2: Opcode 0x02 writes each data byte into the buffer. The first byte goes to the frame address, and each later byte goes one location higher. Addresses wrap modulo 64, and address bits above bit 5 are ignored.
- R3: Opcode 0x03 returns buffer bytes on MISO. It starts at the frame address, increments by one per byte and wraps modulo 64.
- R4: Opcode 0x01 copies every completed data byte into the 8-bit status register, which appears on `stat_q`.
- R5: Opcode 0x04 returns a status byte in every data byte. With `stat_sel`=0 it is `stat_q`; with `stat_sel`=1 it is `stat_rd_i`.
- R6: Opcode 0x06 stores data bytes exactly as R2 does. On MISO, data byte 0 returns the buffer byte at address minus one, and data byte k (k≥1) returns the byte just stored from data byte k-1.
- R7: `spi_miso_en` is high only while chip select is low and the data phase of opcode 0x03, 0x04 or 0x06 is in progress. `spi_miso` is 0 whenever `spi_miso_en` is low.
- R8: Any other opcode writes no storage, never raises `spi_miso_en` and produces no done strobe.
- R9: Chip select going high mid-frame returns the engine to the opcode phase. Bytes already completed stay stored, a partial byte is dropped, no done strobe is issued, and the next frame works normally.
- R10: When chip select rises after a frame with a defined opcode, an address and at least one whole data byte, `done` is high for exactly one clock and `done_op` holds the opcode.
- R11: `sys_we` writes `sys_wdata` into the buffer at `sys_addr`, and `sys_rdata` shows the buffer byte at `sys_addr` in the same cycle. An SPI write to the same location in the same cycle takes precedence.
- R12: After reset, `spi_miso_en`, `done` and `stat_q` are 0, and every buffer byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_en | output | 1 | MISO output enable (pad tri-state control) |
| sys_we | input | 1 | System write strobe into the buffer |
| sys_addr | input | 6 | System buffer address |
| sys_wdata | input | 8 | System write byte |
| sys_rdata | output | 8 | Buffer byte at `sys_addr` |
| stat_rd_i | input | 8 | System-supplied status byte |
| stat_sel | input | 1 | Status read select: 0 = master-written, 1 = system-supplied |
| stat_q | output | 8 | Master-written status register |
| done | output | 1 | One-cycle completed-frame strobe |
| done_op | output | 8 | Opcode of the completed frame |

## Verification
The bench writes all 64 buffer locations over SPI and reads them back over both ports. It then crosses the top of the buffer with both opcodes, with the address's upper bits set. A design that mis-wraps the pointer or decodes too many address bits would return the wrong bytes there. The write-then-read opcode is checked for its one-byte echo lag and for the byte read at address minus one. A design that reads before the write lands, or that forgets the bypass, returns stale data there. Several undefined opcodes are sent, and chip select is pulled mid-opcode and mid-byte. A design that leaks writes, drives MISO or strobes done on those frames is caught. So is one that does not recover for the next frame. Both status sources are read, to catch an ignored select.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_WR_BUF  = 8'h02;
  localparam logic [7:0] OP_RD_BUF  = 8'h03;
  localparam logic [7:0] OP_RD_STAT = 8'h04;
  localparam logic [7:0] OP_WR_RD   = 8'h06;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_WR_STAT) || (op == OP_WR_BUF) || (op == OP_RD_BUF) ||
           (op == OP_RD_STAT) || (op == OP_WR_RD);
  endfunction

  function automatic logic op_sends(input logic [7:0] op);
    return (op == OP_RD_BUF) || (op == OP_RD_STAT) || (op == OP_WR_RD);
  endfunction

  function automatic logic op_writes_buf(input logic [7:0] op);
    return (op == OP_WR_BUF) || (op == OP_WR_RD);
  endfunction

endpackage

// File: rtl/spi_hd_sync.sv
module spi_hd_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_hd_store.sv
module spi_hd_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_buf_we,
  input  logic [AW-1:0] spi_buf_addr,
  input  logic [DW-1:0] spi_wdata,
  input  logic          spi_stat_we,
  input  logic [AW-1:0] spi_rd_addr,
  output logic [DW-1:0] spi_rd_data,
  input  logic          sys_we,
  input  logic [AW-1:0] sys_addr,
  input  logic [DW-1:0] sys_wdata,
  output logic [DW-1:0] sys_rdata,
  output logic [DW-1:0] stat_q
);

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic          ent_en;
    logic [DW-1:0] ent_d;
    logic [DW-1:0] ent_q;

    always_comb begin
      if (spi_buf_we && (spi_buf_addr == AW'(g))) begin
        ent_en = 1'b1;
        ent_d  = spi_wdata;
      end else if (sys_we && (sys_addr == AW'(g))) begin
        ent_en = 1'b1;
        ent_d  = sys_wdata;
      end else begin
        ent_en = 1'b0;
        ent_d  = sys_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign mem[g] = ent_q;
  end

  logic [DW-1:0] stat_d;
  always_comb stat_d = spi_stat_we ? spi_wdata : stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign spi_rd_data = mem[spi_rd_addr];
  assign sys_rdata   = mem[sys_addr];

  // R4: a status write is visible on the next cycle
  a_r4_stat_load: assert property (@(posedge clk) disable iff (!rst_n)
    spi_stat_we |=> (stat_q == $past(spi_wdata)));

  // R11: an SPI buffer write always lands, even against a system write
  a_r11_spi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    spi_buf_we |=> (mem[$past(spi_buf_addr)] == $past(spi_wdata)));

endmodule

// File: rtl/spi_hd_frame.sv
module spi_hd_frame
  import spi_hd_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          cs_s,
  input  logic          mosi_s,
  input  logic [7:0]    rd_data,
  input  logic [7:0]    stat_view,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic          buf_we,
  output logic          stat_we,
  output logic [7:0]    wdata,
  output logic          miso,
  output logic          miso_en,
  output logic          done,
  output logic [7:0]    done_op
);

  logic          sclk_d, cs_d;
  phase_e        phase_q, phase_d;
  logic [2:0]    bitcnt_q, bitcnt_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [7:0]    op_q, op_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          got_q, got_d;
  logic [7:0]    tx_q, tx_d;
  logic          miso_q, miso_d;
  logic          done_q, done_d;
  logic [7:0]    done_op_q, done_op_d;

  logic       rise, fall, cs_rise, byte_end, data_end, load, complete;
  logic [7:0] shin, load_val;

  always_comb begin
    rise     = !cs_s && sclk_s && !sclk_d;
    fall     = !cs_s && !sclk_s && sclk_d;
    cs_rise  = cs_s && !cs_d;
    shin     = {shreg_q[6:0], mosi_s};
    byte_end = rise && (bitcnt_q == 3'd7);
    data_end = byte_end && (phase_q == PH_DATA);
    load     = byte_end && (phase_q != PH_CMD) && op_sends(op_q);
    complete = (phase_q == PH_DATA) && (bitcnt_q == 3'd0) && got_q && op_known(op_q);

    if (phase_q == PH_ADDR)
      rd_addr = (op_q == OP_WR_RD) ? (shin[AW-1:0] - AW'(1)) : shin[AW-1:0];
    else
      rd_addr = ptr_q + AW'(1);

    if (op_q == OP_RD_STAT)                          load_val = stat_view;
    else if (op_q == OP_WR_RD && phase_q == PH_DATA) load_val = shin;
    else                                             load_val = rd_data;

    buf_we  = data_end && op_writes_buf(op_q);
    stat_we = data_end && (op_q == OP_WR_STAT);
    wdata   = shin;
    wr_addr = ptr_q;
  end

  always_comb begin
    phase_d   = phase_q;
    bitcnt_d  = bitcnt_q;
    shreg_d   = shreg_q;
    op_d      = op_q;
    ptr_d     = ptr_q;
    got_d     = got_q;
    tx_d      = tx_q;
    miso_d    = miso_q;
    done_d    = cs_rise && complete;
    done_op_d = (cs_rise && complete) ? op_q : done_op_q;

    if (cs_s) begin
      phase_d  = PH_CMD;
      bitcnt_d = 3'd0;
      shreg_d  = 8'd0;
      got_d    = 1'b0;
      miso_d   = 1'b0;
    end else if (rise) begin
      shreg_d  = shin;
      bitcnt_d = bitcnt_q + 3'd1;
      if (byte_end) begin
        unique case (phase_q)
          PH_CMD: begin
            op_d    = shin;
            phase_d = PH_ADDR;
          end
          PH_ADDR: begin
            ptr_d   = shin[AW-1:0];
            phase_d = PH_DATA;
          end
          default: begin
            got_d = 1'b1;
            if (op_writes_buf(op_q) || op_q == OP_RD_BUF) ptr_d = ptr_q + AW'(1);
          end
        endcase
      end
      if (load) begin
        tx_d   = load_val;
        miso_d = load_val[7];
      end
    end else if (fall) begin
      miso_d = tx_q[3'd7 - bitcnt_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
      phase_q   <= PH_CMD;
      bitcnt_q  <= 3'd0;
      shreg_q   <= 8'd0;
      op_q      <= 8'd0;
      ptr_q     <= '0;
      got_q     <= 1'b0;
      tx_q      <= 8'd0;
      miso_q    <= 1'b0;
      done_q    <= 1'b0;
      done_op_q <= 8'd0;
    end else begin
      sclk_d    <= sclk_s;
      cs_d      <= cs_s;
      phase_q   <= phase_d;
      bitcnt_q  <= bitcnt_d;
      shreg_q   <= shreg_d;
      op_q      <= op_d;
      ptr_q     <= ptr_d;
      got_q     <= got_d;
      tx_q      <= tx_d;
      miso_q    <= miso_d;
      done_q    <= done_d;
      done_op_q <= done_op_d;
    end
  end

  assign miso_en = !cs_s && (phase_q == PH_DATA) && op_sends(op_q);
  assign miso    = miso_en && miso_q;
  assign done    = done_q;
  assign done_op = done_op_q;

  // R1: each sampled SCLK rise advances the bit counter by one
  a_r1_bit_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (bitcnt_q == 3'($past(bitcnt_q) + 3'd1)));

  // R3: read pointer steps once per returned buffer byte
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_end && op_q == OP_RD_BUF) |=> (ptr_q == AW'($past(ptr_q) + AW'(1))));

  // R8: an undefined opcode leaves storage and MISO untouched
  a_r8_unknown_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && !op_known(op_q)) |-> (!miso_en && !buf_we && !stat_we));

  // R9: chip select high returns the frame to the opcode phase
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (phase_q == PH_CMD && bitcnt_q == 3'd0 && !miso_en));

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/spi_hd_slave.sv
module spi_hd_slave #(
  parameter int  DEPTH       = 64,
  parameter int  SYNC_STAGES = 2,
  localparam int AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_en,
  input  logic          sys_we,
  input  logic [AW-1:0] sys_addr,
  input  logic [7:0]    sys_wdata,
  output logic [7:0]    sys_rdata,
  input  logic [7:0]    stat_rd_i,
  input  logic          stat_sel,
  output logic [7:0]    stat_q,
  output logic          done,
  output logic [7:0]    done_op
);

  logic [2:0]    pins_s;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          buf_we, stat_we;
  logic [7:0]    wdata, rd_data, stat_view;

  spi_hd_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sclk, spi_mosi}),
    .q     (pins_s)
  );

  assign stat_view = stat_sel ? stat_rd_i : stat_q;

  spi_hd_frame #(
    .AW (AW)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[1]),
    .cs_s      (pins_s[2]),
    .mosi_s    (pins_s[0]),
    .rd_data   (rd_data),
    .stat_view (stat_view),
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr),
    .buf_we    (buf_we),
    .stat_we   (stat_we),
    .wdata     (wdata),
    .miso      (spi_miso),
    .miso_en   (spi_miso_en),
    .done      (done),
    .done_op   (done_op)
  );

  spi_hd_store #(
    .DEPTH (DEPTH),
    .DW    (8)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .spi_buf_we   (buf_we),
    .spi_buf_addr (wr_addr),
    .spi_wdata    (wdata),
    .spi_stat_we  (stat_we),
    .spi_rd_addr  (rd_addr),
    .spi_rd_data  (rd_data),
    .sys_we       (sys_we),
    .sys_addr     (sys_addr),
    .sys_wdata    (sys_wdata),
    .sys_rdata    (sys_rdata),
    .stat_q       (stat_q)
  );

endmodule

// File: tb/sim_spi_hd_slave.sv
`timescale 1ns/1ps
module sim_spi_hd_slave;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_en;
  logic       sys_we = 1'b0;
  logic [5:0] sys_addr = '0;
  logic [7:0] sys_wdata = '0, sys_rdata;
  logic [7:0] stat_rd_i = '0;
  logic       stat_sel = 1'b0;
  logic [7:0] stat_q, done_op;
  logic       done;

  always #2 clk = ~clk;

  spi_hd_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_en(spi_miso_en),
    .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .sys_rdata(sys_rdata), .stat_rd_i(stat_rd_i), .stat_sel(stat_sel),
    .stat_q(stat_q), .done(done), .done_op(done_op)
  );

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int en_cnt = 0;
  logic [7:0] last_op = '0;
  logic [7:0] mo [0:79];
  logic [7:0] mi [0:79];
  logic [7:0] model [0:63];

  always @(posedge clk) begin
    if (done) begin done_cnt = done_cnt + 1; last_op = done_op; end
    if (spi_miso_en) en_cnt = en_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half_period();
    repeat (8) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    spi_mosi = b;
    half_period();
    r = spi_miso;
    spi_sclk = 1'b1;
    half_period();
    spi_sclk = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(b[i], x);
      r[i] = x;
    end
  endtask

  // op, address, nb whole data bytes, then extra bits of mo[nb]; cmd_bits<8 aborts in opcode
  task automatic xfer(input logic [7:0] op, input logic [7:0] adr, input int nb,
                      input int extra, input int cmd_bits);
    logic [7:0] r;
    logic x;
    spi_cs_n = 1'b0;
    half_period();
    if (cmd_bits < 8) begin
      for (int i = 0; i < cmd_bits; i++) spi_bit(op[7-i], x);
    end else begin
      spi_byte(op, r);
      spi_byte(adr, r);
      for (int k = 0; k < nb; k++) begin
        spi_byte(mo[k], r);
        mi[k] = r;
      end
      for (int i = 0; i < extra; i++) spi_bit(mo[nb][7-i], x);
    end
    half_period();
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic sys_rd(input int a, output logic [7:0] d);
    sys_addr = 6'(a);
    @(negedge clk);
    d = sys_rdata;
  endtask

  task automatic sys_wr(input int a, input logic [7:0] d);
    sys_addr  = 6'(a);
    sys_wdata = d;
    sys_we    = 1'b1;
    @(negedge clk);
    sys_we    = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int dc, ec;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 miso_en", 32'(spi_miso_en), 0);
    chk("R12 done", 32'(done), 0);
    chk("R12 stat_q", 32'(stat_q), 0);
    sys_rd(0, d);  chk("R12 buf[0]", 32'(d), 0);
    sys_rd(63, d); chk("R12 buf[63]", 32'(d), 0);

    // R2 / R1: write all 64 bytes, MSB first
    for (int i = 0; i < 64; i++) begin mo[i] = 8'(i * 37 + 11); model[i] = mo[i]; end
    dc = done_cnt; ec = en_cnt;
    xfer(8'h02, 8'h00, 64, 0, 8);
    chk("R10 done count wr_buf", 32'(done_cnt - dc), 1);
    chk("R10 done_op wr_buf", 32'(last_op), 32'h02);
    chk("R7 no miso_en on write", 32'(en_cnt - ec), 0);
    for (int i = 0; i < 64; i++) begin
      sys_rd(i, d);
      chk($sformatf("R2 R1 buf[%0d]", i), 32'(d), 32'(model[i]));
    end

    // R3: read all 64 back over SPI
    ec = en_cnt;
    xfer(8'h03, 8'h00, 64, 0, 8);
    for (int i = 0; i < 64; i++) chk($sformatf("R3 rd[%0d]", i), 32'(mi[i]), 32'(model[i]));
    chk("R7 miso_en active on read", 32'(en_cnt - ec > 0), 1);
    chk("R7 miso_en idle after", 32'(spi_miso_en), 0);

    // R2 wrap with upper address bits set
    mo[0] = 8'h80; mo[1] = 8'h01; mo[2] = 8'hE7;
    xfer(8'h02, 8'hFE, 3, 0, 8);
    model[62] = 8'h80; model[63] = 8'h01; model[0] = 8'hE7;
    sys_rd(62, d); chk("R2 wrap 62", 32'(d), 32'h80);
    sys_rd(63, d); chk("R2 wrap 63", 32'(d), 32'h01);
    sys_rd(0, d);  chk("R2 wrap 0", 32'(d), 32'hE7);
    xfer(8'h03, 8'h7E, 3, 0, 8);
    chk("R3 wrap 62", 32'(mi[0]), 32'h80);
    chk("R3 wrap 63", 32'(mi[1]), 32'h01);
    chk("R3 wrap 0", 32'(mi[2]), 32'hE7);

    // R11: system write visible to SPI read
    sys_wr(30, 8'hA5); model[30] = 8'hA5;
    sys_rd(30, d); chk("R11 sys readback", 32'(d), 32'hA5);
    xfer(8'h03, 8'd30, 1, 0, 8);
    chk("R11 spi sees sys write", 32'(mi[0]), 32'hA5);

    // R4: status write
    mo[0] = 8'h3C; mo[1] = 8'hC3;
    dc = done_cnt;
    xfer(8'h01, 8'h00, 2, 0, 8);
    chk("R4 stat_q last byte", 32'(stat_q), 32'hC3);
    chk("R10 done_op wr_stat", 32'(last_op), 32'h01);
    chk("R10 done count wr_stat", 32'(done_cnt - dc), 1);

    // R5: status read, both sources
    stat_sel = 1'b0;
    mo[0] = 8'h00; mo[1] = 8'h00;
    xfer(8'h04, 8'h00, 2, 0, 8);
    chk("R5 master status b0", 32'(mi[0]), 32'hC3);
    chk("R5 master status b1", 32'(mi[1]), 32'hC3);
    stat_sel = 1'b1; stat_rd_i = 8'h5A;
    xfer(8'h04, 8'h00, 2, 0, 8);
    chk("R5 sys status b0", 32'(mi[0]), 32'h5A);
    chk("R5 sys status b1", 32'(mi[1]), 32'h5A);
    stat_sel = 1'b0;

    // R6: write then echo
    mo[0] = 8'h11; mo[1] = 8'h22; mo[2] = 8'h33;
    xfer(8'h06, 8'd10, 3, 0, 8);
    chk("R6 echo b0 = buf[addr-1]", 32'(mi[0]), 32'(model[9]));
    chk("R6 echo b1", 32'(mi[1]), 32'h11);
    chk("R6 echo b2", 32'(mi[2]), 32'h22);
    model[10] = 8'h11; model[11] = 8'h22; model[12] = 8'h33;
    for (int i = 10; i < 13; i++) begin
      sys_rd(i, d); chk($sformatf("R6 stored[%0d]", i), 32'(d), 32'(model[i]));
    end
    chk("R10 done_op wr_rd", 32'(last_op), 32'h06);

    // R8: undefined opcodes
    for (int j = 0; j < 6; j++) begin
      logic [7:0] op;
      case (j)
        0: op = 8'h00; 1: op = 8'h05; 2: op = 8'h07;
        3: op = 8'h08; 4: op = 8'h81; default: op = 8'hFF;
      endcase
      mo[0] = 8'hDE; mo[1] = 8'hAD;
      dc = done_cnt; ec = en_cnt;
      xfer(op, 8'd40, 2, 0, 8);
      chk($sformatf("R8 no done op %0h", op), 32'(done_cnt - dc), 0);
      chk($sformatf("R8 no miso_en op %0h", op), 32'(en_cnt - ec), 0);
      sys_rd(40, d); chk($sformatf("R8 buf40 op %0h", op), 32'(d), 32'(model[40]));
      sys_rd(41, d); chk($sformatf("R8 buf41 op %0h", op), 32'(d), 32'(model[41]));
      chk($sformatf("R8 stat op %0h", op), 32'(stat_q), 32'hC3);
    end

    // R9: abort mid data byte
    mo[0] = 8'h77; mo[1] = 8'hFF;
    dc = done_cnt;
    xfer(8'h02, 8'd20, 1, 3, 8);
    model[20] = 8'h77;
    chk("R9 no done on abort", 32'(done_cnt - dc), 0);
    sys_rd(20, d); chk("R9 full byte kept", 32'(d), 32'h77);
    sys_rd(21, d); chk("R9 partial byte dropped", 32'(d), 32'(model[21]));
    // R9: abort in the opcode phase, then recover
    dc = done_cnt;
    xfer(8'h03, 8'd0, 0, 0, 5);
    chk("R9 no done on opcode abort", 32'(done_cnt - dc), 0);
    xfer(8'h03, 8'd20, 2, 0, 8);
    chk("R9 recover b0", 32'(mi[0]), 32'h77);
    chk("R9 recover b1", 32'(mi[1]), 32'(model[21]));
    chk("R10 done after recovery", 32'(done_cnt - dc), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule